// File: doc/BRIEF.md
# Banked Time-Slot Hub Memory Arbiter

This block schedules access from 32 processor cores to one shared hub memory built from eight equal banks. A free-running slot counter steps through eight slots, one per clock. The four even slots each belong to one server core. That core may reach any word of the whole memory. Each odd slot belongs to one group of seven ordinary cores. All of them are served together in that cycle, and each one is tied to the single bank that matches its position in the group.

Every core has a request channel of the valid/ready kind. The core raises `req_valid` with an address, write data and a write flag. It must hold all of them steady until the block answers with either a one-cycle `gnt` pulse or a one-cycle `err` pulse. The arbiter applies back-pressure by withholding that answer until the core's own slot comes round, which takes at most eight cycles. The core may lower `req_valid` in the answer cycle, or keep it high to start a new transfer. Read data is returned on the core's own lane together with `gnt`. An ordinary core that aims outside its bank gets `err` and nothing is performed.

Addresses are word addresses. The top `log2(GSIZE)` bits pick the bank and the low `BANK_AW` bits pick the word inside it. A full-size memory of 64 KB banks of 32-bit words uses `BANK_AW = 14`.

Top module: `hub_slot_arbiter`

## Requirements
- R1: After reset the slot counter is 0. It advances by one each clock and wraps from 7 to 0. A request present in the first cycle after reset from core 0, core 1 or core 8 is answered 1, 2 or 3 cycles later, respectively.
- R2: In slot 2g (g = 0..3) only server core 8g is served. It may read or write any address, and the address's top 3 bits (bits 8:6 with default parameters) choose the bank.
- R3: In slot 2g+1, every pending core 8g+k (k = 1..7) whose address lies in bank k is granted in the same cycle. Each is routed to its own bank k, and bank 0 is unused.
- R4: A request from an ordinary core whose bank field differs from its position k is answered with a one-cycle `err` and no `gnt`. Memory is not modified and its `rsp_data` lane is zero. Server cores never receive `err`.
- R5: `gnt` and read data appear one cycle after the core's slot cycle. The returned word is the content before the access, so a write returns the previous content of that word.
- R6: A request held from the cycle it is raised is answered within 8 cycles.
- R7: `gnt` and `err` are one-cycle pulses, never high together for one core, and are both low in reset. A core's `rsp_data` lane is zero whenever its `gnt` is low.
- R8: A word written by any core is read back at the same address by any other core allowed to reach that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 32 | Request valid, one bit per core |
| req_we | input | 32 | Write flag per core (1 = write) |
| req_addr | input | 32*9 | Word address per core, core c at bits c*9 upward |
| req_wdata | input | 32*32 | Write data per core |
| gnt | output | 32 | Grant pulse per core; read data valid |
| err | output | 32 | Out-of-bank error pulse per core |
| rsp_data | output | 32*32 | Read data lane per core |

## Verification
The bench uses the default parameters: four groups of eight cores, and eight banks of 64 words each. With this size the whole 512-word memory can be filled and tracked by a reference model in a few thousand cycles. The first and last word of each bank, the simultaneous seven-core slot, and the timing right after reset all fall within a short run. Random traffic then mixes in-bank and stray addresses from every core against the model.

// File: rtl/hub_pkg.sv
package hub_pkg;
  // slot owned by a core: even slot for the group's first core, odd otherwise
  function automatic int slot_of(input int core, input int gsize);
    return (core / gsize) * 2 + (((core % gsize) == 0) ? 0 : 1);
  endfunction
endpackage

// File: rtl/hub_slot_seq.sv
module hub_slot_seq #(
  parameter int NSLOTS = 8,
  parameter int SW     = $clog2(NSLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else if (slot == SW'(NSLOTS - 1)) slot <= '0;
    else slot <= slot + 1'b1;
  end
endmodule

// File: rtl/hub_bank_ram.sv
module hub_bank_ram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  // read-before-write single port
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/hub_slot_router.sv
module hub_slot_router #(
  parameter  int NGROUPS = 4,
  parameter  int GSIZE   = 8,
  parameter  int BANK_AW = 6,
  parameter  int DW      = 32,
  parameter  int SW      = 3,
  localparam int NC      = NGROUPS * GSIZE,
  localparam int BSW     = $clog2(GSIZE),
  localparam int AW      = BSW + BANK_AW
) (
  input  logic [SW-1:0]            slot,
  input  logic [NC-1:0]            req_valid,
  input  logic [NC-1:0]            req_we,
  input  logic [NC*AW-1:0]         req_addr,
  input  logic [NC*DW-1:0]         req_wdata,
  output logic [GSIZE-1:0]         bank_en,
  output logic [GSIZE-1:0]         bank_we,
  output logic [GSIZE*BANK_AW-1:0] bank_addr,
  output logic [GSIZE*DW-1:0]      bank_wdata,
  output logic [NC-1:0]            acc,
  output logic [NC-1:0]            rej
);
  logic [BSW-1:0]     sel [NC];
  logic [BANK_AW-1:0] off [NC];
  logic [SW-2:0]      grp;
  logic               odd;

  assign grp = slot[SW-1:1];
  assign odd = slot[0];

  for (genvar c = 0; c < NC; c++) begin : g_split
    assign sel[c] = req_addr[c*AW+BANK_AW +: BSW];
    assign off[c] = req_addr[c*AW +: BANK_AW];
  end

  always_comb begin
    bank_en    = '0;
    bank_we    = '0;
    bank_addr  = '0;
    bank_wdata = '0;
    acc        = '0;
    rej        = '0;
    for (int c = 0; c < NC; c++) begin
      if (req_valid[c] && (int'(grp) == c / GSIZE)) begin
        if ((c % GSIZE) == 0) begin
          if (!odd) begin
            bank_en[sel[c]]                     = 1'b1;
            bank_we[sel[c]]                     = req_we[c];
            bank_addr[sel[c]*BANK_AW +: BANK_AW] = off[c];
            bank_wdata[sel[c]*DW +: DW]          = req_wdata[c*DW +: DW];
            acc[c]                              = 1'b1;
          end
        end else if (odd) begin
          if (int'(sel[c]) == (c % GSIZE)) begin
            bank_en[sel[c]]                     = 1'b1;
            bank_we[sel[c]]                     = req_we[c];
            bank_addr[sel[c]*BANK_AW +: BANK_AW] = off[c];
            bank_wdata[sel[c]*DW +: DW]          = req_wdata[c*DW +: DW];
            acc[c]                              = 1'b1;
          end else begin
            rej[c] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter #(
  parameter  int NGROUPS = 4,
  parameter  int GSIZE   = 8,
  parameter  int BANK_AW = 6,
  parameter  int DW      = 32,
  localparam int NC      = NGROUPS * GSIZE,
  localparam int BSW     = $clog2(GSIZE),
  localparam int AW      = BSW + BANK_AW,
  localparam int NSLOTS  = 2 * NGROUPS,
  localparam int SW      = $clog2(NSLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    req_valid,
  input  logic [NC-1:0]    req_we,
  input  logic [NC*AW-1:0] req_addr,
  input  logic [NC*DW-1:0] req_wdata,
  output logic [NC-1:0]    gnt,
  output logic [NC-1:0]    err,
  output logic [NC*DW-1:0] rsp_data
);
  logic [SW-1:0]            slot_q;
  logic [GSIZE-1:0]         bank_en, bank_we;
  logic [GSIZE*BANK_AW-1:0] bank_addr;
  logic [GSIZE*DW-1:0]      bank_wdata, bank_rd;
  logic [NC-1:0]            acc, rej, gnt_q, err_q;
  logic [NC*BSW-1:0]        addr_bank;
  logic [BSW-1:0]           rd_sel_q [NC];

  hub_slot_seq #(.NSLOTS(NSLOTS), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot(slot_q)
  );

  hub_slot_router #(
    .NGROUPS(NGROUPS), .GSIZE(GSIZE), .BANK_AW(BANK_AW), .DW(DW), .SW(SW)
  ) u_route (
    .slot(slot_q), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .acc(acc), .rej(rej)
  );

  for (genvar b = 0; b < GSIZE; b++) begin : g_bank
    hub_bank_ram #(.DW(DW), .AW(BANK_AW)) u_ram (
      .clk(clk), .en(bank_en[b]), .we(bank_we[b]),
      .addr(bank_addr[b*BANK_AW +: BANK_AW]),
      .wdata(bank_wdata[b*DW +: DW]),
      .rdata(bank_rd[b*DW +: DW])
    );
  end

  for (genvar c = 0; c < NC; c++) begin : g_core
    assign addr_bank[c*BSW +: BSW] = req_addr[c*AW+BANK_AW +: BSW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      err_q <= '0;
      for (int c = 0; c < NC; c++) rd_sel_q[c] <= '0;
    end else begin
      gnt_q <= acc;
      err_q <= rej;
      for (int c = 0; c < NC; c++) rd_sel_q[c] <= addr_bank[c*BSW +: BSW];
    end
  end

  always_comb begin
    for (int c = 0; c < NC; c++)
      rsp_data[c*DW +: DW] = gnt_q[c] ? bank_rd[rd_sel_q[c]*DW +: DW] : '0;
  end

  assign gnt = gnt_q;
  assign err = err_q;
endmodule

// File: rtl/hub_slot_arbiter_chk.sv
module hub_slot_arbiter_chk #(
  parameter  int NGROUPS = 4,
  parameter  int GSIZE   = 8,
  parameter  int BANK_AW = 6,
  localparam int NC      = NGROUPS * GSIZE,
  localparam int BSW     = $clog2(GSIZE),
  localparam int NSLOTS  = 2 * NGROUPS,
  localparam int SW      = $clog2(NSLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NC-1:0]     req_valid,
  input logic [NC*BSW-1:0] addr_bank,
  input logic [NC-1:0]     gnt,
  input logic [NC-1:0]     err,
  input logic [SW-1:0]     slot_q
);
  logic [SW-1:0] exp_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_slot <= '0;
    else exp_slot <= (int'(exp_slot) == NSLOTS - 1) ? '0 : exp_slot + 1'b1;
  end

  a_r1_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q == exp_slot);

  a_r7_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & err) == '0);

  for (genvar c = 0; c < NC; c++) begin : g_c
    logic [3:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_cnt <= '0;
      else if (req_valid[c] && !gnt[c] && !err[c]) begin
        if (wait_cnt != 4'hF) wait_cnt <= wait_cnt + 1'b1;
      end else wait_cnt <= '0;
    end

    // R2 / R3: grants land only one cycle after the core's own slot
    a_r3_gnt_own_slot: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[c] |-> int'($past(slot_q)) == hub_pkg::slot_of(c, GSIZE));

    a_r5_gnt_had_req: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[c] |-> $past(req_valid[c]));

    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err[c] |-> ((c % GSIZE) != 0) && $past(req_valid[c]) &&
                 (int'($past(addr_bank[c*BSW +: BSW])) != (c % GSIZE)));

    a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= 4'd8);
  end
endmodule

bind hub_slot_arbiter hub_slot_arbiter_chk #(
  .NGROUPS(NGROUPS), .GSIZE(GSIZE), .BANK_AW(BANK_AW)
) u_chk (.*);

// File: tb/sim_hub_slot_arbiter.sv
module sim_hub_slot_arbiter;
  localparam int NC = 32;
  localparam int AW = 9;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_we = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]    gnt, err;
  logic [NC*DW-1:0] rsp_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] mem_m [512];
  bit          known [512];

  always #10 clk = ~clk;

  hub_slot_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .gnt(gnt), .err(err), .rsp_data(rsp_data)
  );

  // core, write flag, address, data
  localparam logic [46:0] VEC [12] = '{
    {5'd0,  1'b1, 9'h0C5, 32'hCAFE0001},
    {5'd3,  1'b0, 9'h0C5, 32'h0},
    {5'd3,  1'b1, 9'h0C6, 32'h12345678},
    {5'd24, 1'b0, 9'h0C6, 32'h0},
    {5'd8,  1'b1, 9'h1FF, 32'hDEADBEEF},
    {5'd15, 1'b0, 9'h1FF, 32'h0},
    {5'd9,  1'b0, 9'h040, 32'h0},
    {5'd9,  1'b1, 9'h080, 32'h0BADF00D},
    {5'd16, 1'b0, 9'h080, 32'h0},
    {5'd31, 1'b1, 9'h1C0, 32'h0000FFFF},
    {5'd12, 1'b0, 9'h000, 32'h0},
    {5'd0,  1'b0, 9'h1C0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input int core, input bit we, input int addr, input logic [31:0] wd);
    int n;
    bit exp_err;
    logic [31:0] exp_rd;
    bit kn;
    exp_err = ((core % 8) != 0) && ((addr >> 6) != (core % 8));
    exp_rd = mem_m[addr];
    kn = known[addr];
    req_valid[core] = 1'b1;
    req_we[core] = we;
    req_addr[core*AW +: AW] = addr[8:0];
    req_wdata[core*DW +: DW] = wd;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(gnt[core] || err[core]) && n < 20);
    chk("R6 answered within 8 cycles", 32'(n <= 8), 32'd1);
    if (exp_err) begin
      chk("R4 err pulse", 32'(err[core]), 32'd1);
      chk("R4 no grant", 32'(gnt[core]), 32'd0);
      chk("R4 zero data", rsp_data[core*DW +: DW], 32'd0);
    end else begin
      chk((core % 8 == 0) ? "R2 server grant" : "R3 group grant", 32'(gnt[core]), 32'd1);
      chk("R4 server never err", 32'(err[core]), 32'd0);
      if (kn) chk("R5 R8 returned word", rsp_data[core*DW +: DW], exp_rd);
      if (we) begin
        mem_m[addr] = wd;
        known[addr] = 1'b1;
      end
    end
    req_valid[core] = 1'b0;
    @(negedge clk);
    chk("R7 pulse ends", 32'(gnt[core] | err[core]), 32'd0);
    chk("R7 lane zero", rsp_data[core*DW +: DW], 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset gnt", gnt, 32'd0);
    chk("R7 reset err", err, 32'd0);
    chk("R7 reset data", rsp_data[31:0], 32'd0);

    // R1: first slots after reset
    rst_n = 1'b1;
    req_valid[0] = 1'b1; req_we[0] = 1'b1; req_addr[0 +: AW] = 9'h000;
    req_wdata[0 +: DW] = 32'h11110000;
    req_valid[1] = 1'b1; req_we[1] = 1'b1; req_addr[1*AW +: AW] = 9'h041;
    req_wdata[1*DW +: DW] = 32'h22220001;
    req_valid[8] = 1'b1; req_we[8] = 1'b1; req_addr[8*AW +: AW] = 9'h007;
    req_wdata[8*DW +: DW] = 32'h33330008;
    @(negedge clk);
    chk("R1 core0 at cycle 1", {29'd0, gnt[8], gnt[1], gnt[0]}, 32'b001);
    req_valid[0] = 1'b0;
    @(negedge clk);
    chk("R1 core1 at cycle 2", {29'd0, gnt[8], gnt[1], gnt[0]}, 32'b010);
    req_valid[1] = 1'b0;
    @(negedge clk);
    chk("R1 core8 at cycle 3", {29'd0, gnt[8], gnt[1], gnt[0]}, 32'b100);
    req_valid[8] = 1'b0;
    mem_m[0] = 32'h11110000; known[0] = 1;
    mem_m[9'h041] = 32'h22220001; known[9'h041] = 1;
    mem_m[7] = 32'h33330008; known[7] = 1;
    @(negedge clk);

    // R2: server fills the whole memory
    for (int a = 0; a < 512; a++) run_txn(0, 1'b1, a, 32'(a) * 32'h9E3779B1 ^ 32'h5A5A);

    // vector table
    for (int i = 0; i < 12; i++)
      run_txn(int'(VEC[i][46:42]), VEC[i][41], int'(VEC[i][40:32]), VEC[i][31:0]);

    // R3: all seven cores of group 2 in one slot
    begin
      int n;
      for (int k = 1; k < 8; k++) begin
        req_valid[16+k] = 1'b1; req_we[16+k] = 1'b1;
        req_addr[(16+k)*AW +: AW] = 9'(k*64 + 10);
        req_wdata[(16+k)*DW +: DW] = 32'hA5000000 + 32'(16+k);
      end
      n = 0;
      do begin @(negedge clk); n++; end while (!gnt[17] && n < 20);
      chk("R3 seven grants together", {25'd0, gnt[23:17]}, 32'h7F);
      chk("R3 no others", 32'($countones(gnt)), 32'd7);
      chk("R3 no err", err, 32'd0);
      chk("R6 group wait", 32'(n <= 8), 32'd1);
      for (int k = 1; k < 8; k++) begin
        chk("R5 old word on write", rsp_data[(16+k)*DW +: DW], mem_m[k*64 + 10]);
        mem_m[k*64 + 10] = 32'hA5000000 + 32'(16+k);
        req_valid[16+k] = 1'b0;
      end
      @(negedge clk);
      for (int k = 1; k < 8; k++) run_txn(24, 1'b0, k*64 + 10, 32'h0);
    end

    // R4: stray write leaves memory unchanged
    run_txn(5, 1'b1, 2*64 + 3, 32'hFFFFFFFF);
    run_txn(0, 1'b0, 2*64 + 3, 32'h0);

    // random traffic
    for (int i = 0; i < 300; i++) begin
      int core, addr;
      core = int'($urandom_range(31, 0));
      if ((core % 8) == 0 || $urandom_range(3, 0) == 0) addr = int'($urandom_range(511, 0));
      else addr = (core % 8) * 64 + int'($urandom_range(63, 0));
      run_txn(core, 1'($urandom_range(1, 0)), addr, $urandom());
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule